// File: doc/BRIEF.md
# Graphic RAM Host Access Port

This block connects a byte-wide host bus to an internal graphic display RAM of 16 bytes per row and 64 rows. The host writes a register index with `rs_i` low, then writes or reads that register with `rs_i` high. Index 0 is the RAM data port. The other indices load the X (byte column) counter, the Y (row) counter, the auto-increment control bits and the mode bits. When auto-increment is enabled, each qualifying data access advances X, Y or both after the access, so the host can stream a run of bytes without reloading addresses.

The write path can store each byte with its bit order reversed. Reads return the stored byte as it is. A separate display read port gives the pixel byte at any X/Y location, inverted when reverse polarity is selected. Writing the increment-control register marks the address as invalid. Data accesses are then dropped until both X and Y have been loaded again.

Top module: `gram_host_port`

## Requirements
- R1: After reset, X=0, Y=0, all increment-control bits are 0, swap and reverse are 0, the register index is 0, the address is valid and `host_dout_o` is 0x00.
- R2: With swap=0, a data write stores the host byte unchanged at the current X/Y location.
- R3: With swap=1, a data write stores the byte bit-reversed: host bit i lands in RAM bit 7-i.
- R4: A data read (rd strobe, rs=1, index 0) puts the byte at the current X/Y on `host_dout_o` in the cycle after the strobe, with no bit reversal whatever the swap setting. `host_dout_o` holds its value at all other times.
- R5: `disp_pix_o` is, in the same cycle, the RAM byte at (`disp_x_i`, `disp_y_i`) XOR 0xFF when reverse=1, and unchanged when reverse=0.
- R6: With the X-increment bit set, X advances by one after each qualifying access and wraps from 15 to 0. Y is not affected.
- R7: With the Y-increment bit set, Y advances by one after each qualifying access and wraps from 63 to 0.
- R8: The access-mode bit selects the qualifying access: 0 means data writes, 1 means data reads. The other kind of access leaves X and Y unchanged. A read-triggered step uses the address in place before the read.
- R9: Writing the increment-control register makes the address invalid. Until X and Y have both been loaded again, data writes are dropped, data reads return 0x00, and no increment occurs.
- R10: Register map: an rs=0 write sets the index from din[2:0]. Index 1 loads X from din[3:0]. Index 2 loads Y from din[5:0]. Index 3 loads the increment control (bit0 X-increment, bit1 Y-increment, bit2 access mode). Index 4 loads the mode (bit0 swap, bit1 reverse). Writes to indices 5 to 7 have no effect.
- R11: When the wr and rd strobes are both high, the write is performed and the read is ignored: `host_dout_o` does not change.
- R12: A host write to the location the display port is reading becomes visible on `disp_pix_o` only after the clock edge that performs the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_rs_i | input | 1 | 0 = index write, 1 = register/data access |
| host_wr_i | input | 1 | Write strobe, one cycle per access |
| host_rd_i | input | 1 | Read strobe, one cycle per access |
| host_din_i | input | 8 | Host write data |
| host_dout_o | output | 8 | Registered host read data |
| disp_x_i | input | 4 | Display read byte column |
| disp_y_i | input | 6 | Display read row |
| disp_pix_o | output | 8 | Pixel byte after polarity selection |

## Verification
Two functions can meet in one cycle. The first is a host write and a host read strobe raised together. The bench drives both in one cycle and checks that the byte is stored while the read data output keeps its earlier value. The second is a host write and the display port reading the same location. The bench holds the display address on the target cell while the write strobe is high. It samples just before the edge, where the old byte is expected, and again one half-cycle after, where the new byte is expected.

// File: rtl/gram_pkg.sv
package gram_pkg;

    typedef enum logic [2:0] {
        IDX_DATA = 3'd0,
        IDX_XADR = 3'd1,
        IDX_YADR = 3'd2,
        IDX_INCR = 3'd3,
        IDX_MODE = 3'd4
    } reg_idx_e;

    typedef struct packed {
        logic aim;   // 1: reads qualify, 0: writes qualify
        logic ay1;   // Y auto-step enable
        logic ax1;   // X auto-step enable
    } incr_ctl_t;

    typedef struct packed {
        logic rev;
        logic swap;
    } mode_t;

endpackage

// File: rtl/gram_bitswap.sv
module gram_bitswap #(
    parameter int W = 8
) (
    input  logic         swap_i,
    input  logic [W-1:0] data_i,
    output logic [W-1:0] data_o
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign data_o[i] = swap_i ? data_i[W-1-i] : data_i[i];
    end
endmodule

// File: rtl/gram_array.sv
module gram_array #(
    parameter int XBYTES = 16,
    parameter int YROWS  = 64,
    parameter int DW     = 8,
    localparam int XW    = $clog2(XBYTES),
    localparam int YW    = $clog2(YROWS),
    localparam int DEPTH = XBYTES * YROWS
) (
    input  logic          clk,
    input  logic          we_i,
    input  logic [XW-1:0] wx_i,
    input  logic [YW-1:0] wy_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [XW-1:0] hx_i,
    input  logic [YW-1:0] hy_i,
    output logic [DW-1:0] hdata_o,
    input  logic [XW-1:0] dx_i,
    input  logic [YW-1:0] dy_i,
    output logic [DW-1:0] ddata_o
);
    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we_i) begin
            mem_q[{wy_i, wx_i}] <= wdata_i;
        end
    end

    assign hdata_o = mem_q[{hy_i, hx_i}];
    assign ddata_o = mem_q[{dy_i, dx_i}];
endmodule

// File: rtl/gram_ctrl.sv
module gram_ctrl
    import gram_pkg::*;
#(
    parameter int XBYTES = 16,
    parameter int YROWS  = 64,
    localparam int XW    = $clog2(XBYTES),
    localparam int YW    = $clog2(YROWS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rs_i,
    input  logic          wr_i,
    input  logic          rd_i,
    input  logic [7:0]    din_i,
    output logic [XW-1:0] x_o,
    output logic [YW-1:0] y_o,
    output mode_t         mode_o,
    output logic          ram_we_o,
    output logic          ram_rd_o,
    output logic          dat_rd_o
);
    localparam logic [XW-1:0] XMAX = XW'(XBYTES - 1);
    localparam logic [YW-1:0] YMAX = YW'(YROWS - 1);

    typedef struct packed {
        logic [2:0]    idx;
        logic [XW-1:0] x;
        logic [YW-1:0] y;
        incr_ctl_t     inc;
        mode_t         mode;
        logic          valid;
        logic          xset;
        logic          yset;
    } ctl_st_t;

    ctl_st_t st_d, st_q;
    logic    we_d, rd_d, datrd_d, step_d;

    always_comb begin
        st_d    = st_q;
        we_d    = 1'b0;
        rd_d    = 1'b0;
        datrd_d = 1'b0;
        step_d  = 1'b0;

        if (wr_i && !rs_i) begin
            st_d.idx = din_i[2:0];
        end else if (wr_i && rs_i) begin
            unique case (st_q.idx)
                IDX_DATA: begin
                    we_d   = st_q.valid;
                    step_d = st_q.valid && !st_q.inc.aim;
                end
                IDX_XADR: begin
                    st_d.x    = din_i[XW-1:0];
                    st_d.xset = 1'b1;
                end
                IDX_YADR: begin
                    st_d.y    = din_i[YW-1:0];
                    st_d.yset = 1'b1;
                end
                IDX_INCR: begin
                    st_d.inc   = din_i[2:0];
                    st_d.valid = 1'b0;
                    st_d.xset  = 1'b0;
                    st_d.yset  = 1'b0;
                end
                IDX_MODE: begin
                    st_d.mode = din_i[1:0];
                end
                default: ;
            endcase
        end else if (rd_i && rs_i && st_q.idx == IDX_DATA) begin
            datrd_d = 1'b1;
            rd_d    = st_q.valid;
            step_d  = st_q.valid && st_q.inc.aim;
        end

        if (st_d.xset && st_d.yset) begin
            st_d.valid = 1'b1;
        end

        if (step_d) begin
            if (st_q.inc.ax1) begin
                st_d.x = (st_q.x == XMAX) ? '0 : st_q.x + XW'(1);
            end
            if (st_q.inc.ay1) begin
                st_d.y = (st_q.y == YMAX) ? '0 : st_q.y + YW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{idx: 3'd0, x: '0, y: '0, inc: '0, mode: '0,
                      valid: 1'b1, xset: 1'b1, yset: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    assign x_o      = st_q.x;
    assign y_o      = st_q.y;
    assign mode_o   = st_q.mode;
    assign ram_we_o = we_d;
    assign ram_rd_o = rd_d;
    assign dat_rd_o = datrd_d;

    // R6: a write-qualified step moves X by one with wrap
    assert_x_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && rs_i && st_q.idx == 3'd0 && st_q.valid && st_q.inc.ax1 && !st_q.inc.aim)
        |=> (st_q.x == (($past(st_q.x) == XMAX) ? '0 : $past(st_q.x) + XW'(1))));

    // R8: with no strobe the counters do not move
    assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_i && !rd_i) |=> ($stable(st_q.x) && $stable(st_q.y)));

    // R9: writing the increment control drops validity
    assert_invalidate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && rs_i && st_q.idx == 3'd3) |=> !st_q.valid);

    // R9: no RAM write while the address is invalid
    assert_no_write_invalid_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.valid |-> !ram_we_o);
endmodule

// File: rtl/gram_host_port.sv
module gram_host_port
    import gram_pkg::*;
#(
    parameter int XBYTES = 16,
    parameter int YROWS  = 64,
    localparam int XW    = $clog2(XBYTES),
    localparam int YW    = $clog2(YROWS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_rs_i,
    input  logic          host_wr_i,
    input  logic          host_rd_i,
    input  logic [7:0]    host_din_i,
    output logic [7:0]    host_dout_o,
    input  logic [XW-1:0] disp_x_i,
    input  logic [YW-1:0] disp_y_i,
    output logic [7:0]    disp_pix_o
);
    logic [XW-1:0] x;
    logic [YW-1:0] y;
    mode_t         mode;
    logic          ram_we, ram_rd, dat_rd;
    logic [7:0]    wdata, hdata, ddata;
    logic [7:0]    dout_d, dout_q;

    gram_ctrl #(.XBYTES(XBYTES), .YROWS(YROWS)) ctrl_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .rs_i    (host_rs_i),
        .wr_i    (host_wr_i),
        .rd_i    (host_rd_i),
        .din_i   (host_din_i),
        .x_o     (x),
        .y_o     (y),
        .mode_o  (mode),
        .ram_we_o(ram_we),
        .ram_rd_o(ram_rd),
        .dat_rd_o(dat_rd)
    );

    gram_bitswap #(.W(8)) swap_i (
        .swap_i(mode.swap),
        .data_i(host_din_i),
        .data_o(wdata)
    );

    gram_array #(.XBYTES(XBYTES), .YROWS(YROWS), .DW(8)) array_i (
        .clk    (clk),
        .we_i   (ram_we),
        .wx_i   (x),
        .wy_i   (y),
        .wdata_i(wdata),
        .hx_i   (x),
        .hy_i   (y),
        .hdata_o(hdata),
        .dx_i   (disp_x_i),
        .dy_i   (disp_y_i),
        .ddata_o(ddata)
    );

    always_comb begin
        dout_d = dout_q;
        if (dat_rd) begin
            dout_d = ram_rd ? hdata : 8'h00;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dout_q <= 8'h00;
        else        dout_q <= dout_d;
    end

    assign host_dout_o = dout_q;
    assign disp_pix_o  = ddata ^ {8{mode.rev}};

    // R4: read data changes only after an accepted data read
    assert_dout_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !dat_rd |=> $stable(host_dout_o));

    // R11: a write in the same cycle as a read leaves the read data alone
    assert_wr_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr_i && host_rd_i) |=> $stable(host_dout_o));

    // R2/R3: the RAM write only happens on a host data write
    assert_we_source_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> (host_wr_i && host_rs_i));
endmodule

// File: tb/gram_host_port_tb_top.sv
module gram_host_port_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rs = 1'b0, wr = 1'b0, rd = 1'b0;
    logic [7:0] din = 8'h00;
    logic [7:0] dout, pix;
    logic [3:0] dx = 4'd0;
    logic [5:0] dy = 6'd0;
    int         n_run = 0, n_fail = 0;
    bit         done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    gram_host_port dut_i (
        .clk(clk), .rst_n(rst_n),
        .host_rs_i(rs), .host_wr_i(wr), .host_rd_i(rd),
        .host_din_i(din), .host_dout_o(dout),
        .disp_x_i(dx), .disp_y_i(dy), .disp_pix_o(pix)
    );

    // {swap[3:0], x[3:0], y[7:0], din[7:0], expected stored[7:0]}
    localparam logic [31:0] VEC [6] = '{
        {4'd0, 4'd0,  8'd0,  8'hA5, 8'hA5},
        {4'd1, 4'd1,  8'd0,  8'h01, 8'h80},
        {4'd1, 4'd2,  8'd5,  8'h1E, 8'h78},
        {4'd0, 4'd15, 8'd63, 8'h3C, 8'h3C},
        {4'd1, 4'd7,  8'd32, 8'hB2, 8'h4D},
        {4'd0, 4'd3,  8'd10, 8'hFF, 8'hFF}
    };

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic r, input logic [7:0] d);
        @(negedge clk);
        rs = r; wr = 1'b1; din = d;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic set_reg(input logic [2:0] idx, input logic [7:0] v);
        bus_wr(1'b0, {5'd0, idx});
        bus_wr(1'b1, v);
    endtask

    task automatic bus_rd();
        @(negedge clk);
        rs = 1'b1; rd = 1'b1;
        @(negedge clk);
        rd = 1'b0;
    endtask

    task automatic pix_at(input string tag, input int x, input int y, input logic [7:0] exp);
        dx = 4'(x); dy = 6'(y);
        #1;
        check(tag, pix, exp);
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_fail++; n_run++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        check("R1 dout after reset", dout, 8'h00);
        bus_wr(1'b1, 8'h6B);          // index 0, valid, swap 0, lands at (0,0)
        pix_at("R1 default address/mode", 0, 0, 8'h6B);

        // R2/R3: table walk
        foreach (VEC[i]) begin
            set_reg(3'd4, {7'd0, VEC[i][28]});
            set_reg(3'd1, {4'd0, VEC[i][27:24]});
            set_reg(3'd2, VEC[i][23:16]);
            set_reg(3'd0, VEC[i][15:8]);
            pix_at(VEC[i][28] ? "R3 swapped store" : "R2 plain store",
                   int'(VEC[i][27:24]), int'(VEC[i][21:16]), VEC[i][7:0]);
        end

        // R4: read back (swap still 0 here; set swap 1 to prove no reversal)
        set_reg(3'd4, 8'h01);
        set_reg(3'd1, 8'd1);
        set_reg(3'd2, 8'd0);
        bus_wr(1'b0, 8'd0);
        @(negedge clk); rs = 1'b1; rd = 1'b1;
        #1 check("R4 dout before edge", dout, 8'h00);
        @(negedge clk); rd = 1'b0;
        check("R4 read unreversed", dout, 8'h80);

        // R5: reverse polarity
        set_reg(3'd4, 8'h02);
        pix_at("R5 reverse on", 1, 0, 8'h7F);
        set_reg(3'd4, 8'h00);
        pix_at("R5 reverse off", 1, 0, 8'h80);

        // R6: X auto-step and wrap
        set_reg(3'd3, 8'h01);
        set_reg(3'd1, 8'd14);
        set_reg(3'd2, 8'd2);
        set_reg(3'd0, 8'h10);
        bus_wr(1'b1, 8'h20);
        bus_wr(1'b1, 8'h30);
        pix_at("R6 x=14", 14, 2, 8'h10);
        pix_at("R6 x=15", 15, 2, 8'h20);
        pix_at("R6 wrap to 0", 0, 2, 8'h30);

        // R7: Y auto-step and wrap
        set_reg(3'd3, 8'h02);
        set_reg(3'd1, 8'd4);
        set_reg(3'd2, 8'd62);
        set_reg(3'd0, 8'h41);
        bus_wr(1'b1, 8'h42);
        bus_wr(1'b1, 8'h43);
        pix_at("R7 y=62", 4, 62, 8'h41);
        pix_at("R7 y=63", 4, 63, 8'h42);
        pix_at("R7 wrap to 0", 4, 0, 8'h43);

        // R8: read-qualified stepping
        set_reg(3'd3, 8'h05);
        set_reg(3'd1, 8'd0);
        set_reg(3'd2, 8'd20);
        set_reg(3'd0, 8'h55);
        bus_wr(1'b1, 8'h66);          // writes do not step: overwrites (0,20)
        pix_at("R8 write no step", 0, 20, 8'h66);
        bus_rd();
        check("R8 read uses prior address", dout, 8'h66);
        bus_wr(1'b1, 8'h77);          // X now 1
        pix_at("R8 step after read", 1, 20, 8'h77);
        pix_at("R8 old cell kept", 0, 20, 8'h66);

        // R9: invalid address drops accesses
        set_reg(3'd3, 8'h00);
        set_reg(3'd1, 8'd5);
        set_reg(3'd2, 8'd40);
        set_reg(3'd0, 8'h12);
        set_reg(3'd3, 8'h01);
        set_reg(3'd0, 8'h99);
        bus_rd();
        check("R9 read while invalid", dout, 8'h00);
        set_reg(3'd2, 8'd40);
        set_reg(3'd0, 8'h98);
        pix_at("R9 writes dropped", 5, 40, 8'h12);
        set_reg(3'd1, 8'd9);
        set_reg(3'd0, 8'h97);
        bus_wr(1'b1, 8'h96);
        pix_at("R9 valid again", 9, 40, 8'h97);
        pix_at("R9 step resumes", 10, 40, 8'h96);

        // R10: unused index ignored
        set_reg(3'd5, 8'h03);
        pix_at("R10 index 5 ignored", 9, 40, 8'h97);
        set_reg(3'd0, 8'hC1);         // lands at (11,40) unswapped if mode untouched
        pix_at("R10 mode unchanged", 11, 40, 8'hC1);

        // R11: write and read together
        set_reg(3'd3, 8'h00);
        set_reg(3'd1, 8'd2);
        set_reg(3'd2, 8'd50);
        set_reg(3'd0, 8'h21);
        bus_rd();
        check("R11 setup read", dout, 8'h21);
        @(negedge clk); rs = 1'b1; wr = 1'b1; rd = 1'b1; din = 8'h44;
        @(negedge clk); wr = 1'b0; rd = 1'b0;
        check("R11 dout unchanged", dout, 8'h21);
        pix_at("R11 write done", 2, 50, 8'h44);

        // R12: same-cycle write and display read
        dx = 4'd2; dy = 6'd50;
        @(negedge clk); rs = 1'b1; wr = 1'b1; din = 8'h5C;
        #3 check("R12 old before edge", pix, 8'h44);
        @(negedge clk); wr = 1'b0;
        check("R12 new after edge", pix, 8'h5C);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule